// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the execute-stage arithmetic/logic unit of a small 32-bit integer core, bundled with the local decoder that selects its operation. The main instruction decoder supplies a 2-bit operation class. For memory-reference instructions the class forces an add so that the unit forms an address. For a compare-and-branch the class forces a subtract, and the zero flag then reports whether the two operands are equal. For register-format instructions the class hands control to the 6-bit function field of the instruction.

The second decode level turns the class and the function field into a 4-bit operation select. The select is exported so that the surrounding pipeline can observe it. The datapath computes bitwise and, bitwise or, add, subtract or signed set-less-than on two 32-bit operands and flags a zero result. The unit has no clock and no state: every output depends only on the present inputs.

Top module: `alu2l_unit`

## Requirements
- R1: `alu_sel` only ever takes one of five codes: 0000 for and, 0001 for or, 0010 for add, 0110 for subtract and 0111 for set-less-than. `result` is the output of the operation that the code names.
- R2: With `op_class` = 00 the select is add (0010) for any value of `funct`.
- R3: With `op_class` = 01 the select is subtract (0110) for any value of `funct`.
- R4: With `op_class` = 10 the select comes from `funct`: 32 gives add, 34 subtract, 36 and, 37 or, 42 set-less-than.
- R5: Add and subtract are modulo 2^32. A result that overflows wraps around and raises no flag.
- R6: With `op_class` = 10, any `funct` value not listed in R4 selects add.
- R7: With `op_class` = 11 the select is add for any value of `funct`.
- R8: `zero` is 1 exactly when `result` is all zeros. After a subtract it therefore shows whether the two operands are equal.
- R9: Set-less-than compares the operands as signed two's-complement numbers and returns 32'd1 when `opnd_a` < `opnd_b`, else 32'd0.
- R10: The unit is purely combinational. Its outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of a register-format instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| alu_sel | output | 4 | Decoded 4-bit operation select |

## Verification
The unit holds no state, so any decode or datapath fault appears at the ports as soon as the inputs settle, with no latency to wait out. A wrong decode shows first on `alu_sel`, and on `result` whenever the two candidate operations disagree for the applied operands. The bench therefore uses operands that separate the five operations. A carry-in or operand-inversion fault shows only on add or subtract patterns with carries. A sign-handling fault in set-less-than shows only when the operand signs differ. For that reason the mixed-sign and extreme values are driven explicitly.

// File: rtl/alu2l_pkg.sv
package alu2l_pkg;

    localparam int DATA_W  = 32;
    localparam int FUNCT_W = 6;
    localparam int SEL_W   = 4;
    localparam int CLASS_W = 2;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEMREF = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REGFMT = 2'b10,
        CLS_SPARE  = 2'b11
    } op_class_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111
    } alu_sel_e;

    typedef enum logic [1:0] {
        PICK_AND = 2'd0,
        PICK_OR  = 2'd1,
        PICK_SUM = 2'd2,
        PICK_LT  = 2'd3
    } res_pick_e;

    typedef struct packed {
        logic      invert_b;
        res_pick_e pick;
    } dp_ctl_t;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'd36;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'd37;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

    // Second decode level: function field of register-format instructions.
    function automatic alu_sel_e funct_to_sel(input logic [FUNCT_W-1:0] fn);
        alu_sel_e s;
        case (fn)
            FN_SUB:  s = SEL_SUB;
            FN_AND:  s = SEL_AND;
            FN_OR:   s = SEL_OR;
            FN_SLT:  s = SEL_SLT;
            default: s = SEL_ADD;
        endcase
        return s;
    endfunction

    function automatic dp_ctl_t sel_to_ctl(input alu_sel_e s);
        dp_ctl_t c;
        c.invert_b = 1'b0;
        c.pick     = PICK_SUM;
        case (s)
            SEL_AND: c.pick = PICK_AND;
            SEL_OR:  c.pick = PICK_OR;
            SEL_SUB: c.invert_b = 1'b1;
            SEL_SLT: begin
                c.invert_b = 1'b1;
                c.pick     = PICK_LT;
            end
            default: c.pick = PICK_SUM;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu2l_decode.sv
module alu2l_decode
    import alu2l_pkg::*;
#(
    parameter int FW = FUNCT_W
) (
    input  op_class_e         cls_i,
    input  logic [FW-1:0]     funct_i,
    output alu_sel_e          sel_o
);

    alu_sel_e fn_sel;

    always_comb begin
        fn_sel = funct_to_sel(funct_i);
        case (cls_i)
            CLS_MEMREF: sel_o = SEL_ADD;
            CLS_BRANCH: sel_o = SEL_SUB;
            CLS_REGFMT: sel_o = fn_sel;
            default:    sel_o = SEL_ADD;
        endcase
    end

endmodule

// File: rtl/alu2l_addsub.sv
module alu2l_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         lt_o
);

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        // signed less-than: differing signs decide directly
        lt_o  = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : sum_o[W-1];
    end

endmodule

// File: rtl/alu2l_zero.sv
module alu2l_zero #(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    localparam int NCHUNK = (W + CHUNK - 1) / CHUNK;
    localparam int PADW   = NCHUNK * CHUNK;

    logic [PADW-1:0]   padded;
    logic [NCHUNK-1:0] any_set;

    assign padded = {{(PADW-W){1'b0}}, val_i};

    generate
        for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
            assign any_set[k] = |padded[k*CHUNK +: CHUNK];
        end
    endgenerate

    assign zero_o = ~|any_set;

endmodule

// File: rtl/alu2l_core.sv
module alu2l_core
    import alu2l_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_sel_e     sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         zero_o
);

    dp_ctl_t      ctl;
    logic [W-1:0] sum;
    logic         lt;

    assign ctl = sel_to_ctl(sel_i);

    alu2l_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (ctl.invert_b),
        .sum_o (sum),
        .lt_o  (lt)
    );

    always_comb begin
        case (ctl.pick)
            PICK_AND: res_o = a_i & b_i;
            PICK_OR:  res_o = a_i | b_i;
            PICK_LT:  res_o = {{(W-1){1'b0}}, lt};
            default:  res_o = sum;
        endcase
    end

    alu2l_zero #(.W(W)) u_zero (
        .val_i  (res_o),
        .zero_o (zero_o)
    );

endmodule

// File: rtl/alu2l_unit.sv
module alu2l_unit
    import alu2l_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int FW = FUNCT_W
) (
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FW-1:0]      funct,
    input  logic [W-1:0]       opnd_a,
    input  logic [W-1:0]       opnd_b,
    output logic [W-1:0]       result,
    output logic               zero,
    output logic [SEL_W-1:0]   alu_sel
);

    op_class_e cls;
    alu_sel_e  sel;

    assign cls     = op_class_e'(op_class);
    assign alu_sel = sel;

    alu2l_decode #(.FW(FW)) u_decode (
        .cls_i   (cls),
        .funct_i (funct),
        .sel_o   (sel)
    );

    alu2l_core #(.W(W)) u_core (
        .sel_i  (sel),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .res_o  (result),
        .zero_o (zero)
    );

endmodule

// File: rtl/alu2l_unit_chk.sv
module alu2l_unit_chk #(
    parameter int W  = 32,
    parameter int FW = 6
) (
    input logic [1:0]    op_class,
    input logic [FW-1:0] funct,
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [W-1:0]  result,
    input logic          zero,
    input logic [3:0]    alu_sel
);

    logic known;
    assign known = !$isunknown({op_class, funct, opnd_a, opnd_b, result, zero, alu_sel});

    always_comb begin
        if (known) begin
            // R1
            sel_legal_chk: assert (alu_sel == 4'b0000 || alu_sel == 4'b0001 ||
                                   alu_sel == 4'b0010 || alu_sel == 4'b0110 ||
                                   alu_sel == 4'b0111);
            // R2
            memref_add_chk: assert (op_class != 2'b00 || alu_sel == 4'b0010);
            // R3
            branch_sub_chk: assert (op_class != 2'b01 || alu_sel == 4'b0110);
            // R7
            spare_add_chk: assert (op_class != 2'b11 || alu_sel == 4'b0010);
            // R5
            add_wrap_chk: assert (alu_sel != 4'b0010 || result == opnd_a + opnd_b);
            // R8
            sub_equal_chk: assert (alu_sel != 4'b0110 || zero == (opnd_a == opnd_b));
            // R9
            slt_bool_chk: assert (alu_sel != 4'b0111 ||
                                  result == {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
        end
    end

endmodule

bind alu2l_unit alu2l_unit_chk #(.W(W), .FW(FW)) u_chk (
    .op_class (op_class),
    .funct    (funct),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .zero     (zero),
    .alu_sel  (alu_sel)
);

// File: tb/tb_alu2l_unit.sv
module tb_alu2l_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]  op_class;
    logic [5:0]  funct;
    logic [31:0] opnd_a, opnd_b, result;
    logic        zero;
    logic [3:0]  alu_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    alu2l_unit dut (
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .zero     (zero),
        .alu_sel  (alu_sel)
    );

    // {class, funct, a, b, exp_result, exp_zero, exp_sel}
    localparam int NV = 16;
    localparam logic [108:0] VEC [NV] = '{
        {2'b00, 6'd0,  32'd5,         32'd7,         32'd12,        1'b0, 4'b0010}, // R2
        {2'b00, 6'd34, 32'hFFFF_FFFF, 32'd1,         32'd0,         1'b1, 4'b0010}, // R2 R5
        {2'b01, 6'd32, 32'd9,         32'd9,         32'd0,         1'b1, 4'b0110}, // R3 R8
        {2'b01, 6'd0,  32'd3,         32'd9,         32'hFFFF_FFFA, 1'b0, 4'b0110}, // R3 R5
        {2'b10, 6'd32, 32'h7FFF_FFFF, 32'd1,         32'h8000_0000, 1'b0, 4'b0010}, // R4 R5
        {2'b10, 6'd34, 32'd10,        32'd3,         32'd7,         1'b0, 4'b0110}, // R4
        {2'b10, 6'd36, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0, 4'b0000}, // R4 R1
        {2'b10, 6'd37, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 1'b0, 4'b0001}, // R4 R1
        {2'b10, 6'd42, 32'hFFFF_FFFF, 32'd1,         32'd1,         1'b0, 4'b0111}, // R9
        {2'b10, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0,         1'b1, 4'b0111}, // R9
        {2'b10, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1,         1'b0, 4'b0111}, // R9
        {2'b10, 6'd42, 32'd5,         32'd5,         32'd0,         1'b1, 4'b0111}, // R9 R8
        {2'b10, 6'd0,  32'd2,         32'd3,         32'd5,         1'b0, 4'b0010}, // R6
        {2'b10, 6'd63, 32'd0,         32'd0,         32'd0,         1'b1, 4'b0010}, // R6 R8
        {2'b11, 6'd36, 32'd4,         32'd4,         32'd8,         1'b0, 4'b0010}, // R7
        {2'b10, 6'd36, 32'h0000_000F, 32'h0000_00F0, 32'd0,         1'b1, 4'b0000}  // R8
    };

    function automatic logic [3:0] ref_sel(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b01) return 4'b0110;
        if (c != 2'b10) return 4'b0010;
        case (f)
            6'd34:   return 4'b0110;
            6'd36:   return 4'b0000;
            6'd37:   return 4'b0001;
            6'd42:   return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    function automatic logic [31:0] ref_res(input logic [3:0] s, input logic [31:0] a,
                                            input logic [31:0] b);
        case (s)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0110: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_class = c; funct = f; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] er, input logic ez,
                         input logic [3:0] es);
        checks++;
        if (result !== er || zero !== ez || alu_sel !== es) begin
            fails++;
            $display("FAIL %s: actual res=%h zero=%b sel=%b expected res=%h zero=%b sel=%b",
                     req, result, zero, alu_sel, er, ez, es);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] ea, eb;
        logic [3:0]  es;
        logic [31:0] er;
        logic [5:0]  fl [8];
        fl = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd0, 6'd1, 6'd63};
        op_class = '0; funct = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state inputs: class 00, zero operands -> add of zeros (R2, R8)
        check("R2_R8_reset", 32'd0, 1'b1, 4'b0010);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][108:107], VEC[i][106:101], VEC[i][100:69], VEC[i][68:37]);
            check($sformatf("R1_R9_vec%0d", i), VEC[i][36:5], VEC[i][4], VEC[i][3:0]);
        end

        // every class with listed and unlisted function codes, random operands (R4 R6 R7)
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k++) begin
                for (int n = 0; n < 20; n++) begin
                    ea = $urandom;
                    eb = (n % 5 == 0) ? ea : $urandom;
                    es = ref_sel(2'(c), fl[k]);
                    er = ref_res(es, ea, eb);
                    apply(2'(c), fl[k], ea, eb);
                    check("R4_R6_R7_R8_rand", er, (er == 32'd0), es);
                end
            end
        end

        // signed boundaries for set-less-than (R9)
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic [31:0] bv [5];
                bv = '{32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'd1, 32'h7FFF_FFFF};
                er = ($signed(bv[i]) < $signed(bv[j])) ? 32'd1 : 32'd0;
                apply(2'b10, 6'd42, bv[i], bv[j]);
                check("R9_bound", er, (er == 32'd0), 4'b0111);
            end
        end

        // combinational response without a clock edge (R10)
        op_class = 2'b10; funct = 6'd34; opnd_a = 32'd100; opnd_b = 32'd100;
        #1;
        check("R10_comb_a", 32'd0, 1'b1, 4'b0110);
        funct = 6'd37; opnd_b = 32'h0000_0F00;
        #1;
        check("R10_comb_b", 32'h0000_0F64, 1'b0, 4'b0001);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule